// File: doc/BRIEF.md
# Flash Command and Status Controller

This block models the command side of a byte-wide, single-supply flash array of eight equal sectors. A processor reaches it through a plain synchronous bus of active-high chip select, write and read strobes, a 17-bit address and byte-wide data. Ordinary write cycles feed an unlock-and-command sequence. That sequence starts one of three timed operations: a one-byte program, a sector erase or a chip erase. While an operation runs, reads return polling status instead of array data. When the operation ends, the block goes back to array reads without any further command.

The array is held in registers. The sector is chosen by the top three address bits, [16:14]. Inside each sector, only the low `OFF_W` address bits are stored, so higher offset bits alias onto the stored bytes. Pulse widths are modelled with cycle counters. An 8-bit protect mask blocks changes to chosen sectors. A low-supply input rejects every write cycle while it is asserted.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every stored byte reads 0xFF, and `dout` holds 0x00 until the first read. A read is a cycle with `cs` and `rd` high, and `dout` shows its result one clock later.
- R2: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, followed by a data write to any address, program that byte. The unlock addresses are compared on address bits [14:0].
- R3: A program only clears bits. The stored byte becomes the old byte ANDed with the written data.
- R4: While an operation is busy, `dout[7]` reads as the inverse of bit 7 of the programmed data during a program, and as 0 during an erase.
- R5: While busy, `dout[6]` inverts on every read, and `dout[5:0]` read 0.
- R6: When an operation finishes, reads return array data again with no further command.
- R7: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at any address in a sector, set all bytes of that sector to 0xFF and leave the other sectors unchanged. Each sector erase first writes 0x00 to every stored byte of the sector, one byte per cycle, and then waits `ERASE_CYCLES` cycles before the clear.
- R8: The same erase prefix followed by 0x10 at 0x5555 erases every sector, from sector 0 upward, and skips sectors that are protected.
- R9: When `prot_mask[s]` is 1, no program or erase changes sector s. A program or sector-erase command aimed at a protected sector does not start, and the block stays in read mode.
- R10: While `low_vdd` is 1, write cycles are ignored and do not advance the command sequence.
- R11: A write of 0xF0, or any write that does not match the next expected step of the sequence, returns the decoder to read mode without changing the array.
- R12: Write cycles made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe, one write per cycle while cs is high |
| rd | input | 1 | Read strobe, one read per cycle while cs is high |
| addr | input | 17 | Byte address, bits [16:14] pick the sector |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or polling status |
| prot_mask | input | 8 | Per-sector protection, 1 blocks changes |
| low_vdd | input | 1 | Low-supply detect, 1 inhibits writes |

## Verification
The bench keeps the default 17-bit address, eight sectors and 16 stored bytes per sector. It keeps `PROG_CYCLES` at 16, which leaves room to send a complete second command while a program is still busy. It lowers `ERASE_CYCLES` to 40, so one sector erase lasts tens of cycles and a chip erase of all eight sectors fits in a short run. With these values the bench can reach the toggle and polling reads in mid-operation, the skipping of protected sectors during a chip erase, and a complete preprogram walk of each sector.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    DS_READ  = 3'd0,
    DS_UNL1  = 3'd1,
    DS_UNL2  = 3'd2,
    DS_PDATA = 3'd3,
    DS_ESET  = 3'd4,
    DS_EUNL1 = 3'd5,
    DS_EUNL2 = 3'd6
  } dec_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_PRE   = 2'd2,
    SQ_ERASE = 2'd3
  } seq_e;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_RESET    = 8'hF0;

endpackage

// File: rtl/fcc_cmd_decoder.sv
module fcc_cmd_decoder
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SEC_W  = 3,
  parameter int OFF_W  = 4,
  parameter int UNL_W  = 15,
  localparam int NSEC  = 1 << SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              lowv,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [NSEC-1:0]   prot,
  output logic              launch,
  output op_e               launch_op,
  output logic [SEC_W-1:0]  launch_sec,
  output logic [OFF_W-1:0]  launch_off,
  output logic [7:0]        launch_data
);

  localparam logic [UNL_W-1:0] ADR_A = UNL_W'(15'h5555);
  localparam logic [UNL_W-1:0] ADR_B = UNL_W'(15'h2AAA);

  dec_e             st_q, st_d;
  logic             launch_q, launch_d;
  op_e              op_q, op_d;
  logic [SEC_W-1:0] sec_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       data_q;

  logic             acc;
  logic             at_a, at_b;
  logic [SEC_W-1:0] cur_sec;

  assign acc     = wr_stb && !lowv && !busy;
  assign at_a    = (addr[UNL_W-1:0] == ADR_A);
  assign at_b    = (addr[UNL_W-1:0] == ADR_B);
  assign cur_sec = addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    st_d     = st_q;
    launch_d = 1'b0;
    op_d     = op_q;
    if (acc) begin
      st_d = DS_READ;
      unique case (st_q)
        DS_READ:  if (at_a && data == CMD_UNLOCK_A) st_d = DS_UNL1;
        DS_UNL1:  if (at_b && data == CMD_UNLOCK_B) st_d = DS_UNL2;
        DS_UNL2: begin
          if (at_a && data == CMD_PROGRAM)    st_d = DS_PDATA;
          else if (at_a && data == CMD_ERASE) st_d = DS_ESET;
        end
        DS_PDATA: begin
          if (!prot[cur_sec]) begin
            launch_d = 1'b1;
            op_d     = OP_PROG;
          end
        end
        DS_ESET:  if (at_a && data == CMD_UNLOCK_A) st_d = DS_EUNL1;
        DS_EUNL1: if (at_b && data == CMD_UNLOCK_B) st_d = DS_EUNL2;
        DS_EUNL2: begin
          if (data == CMD_SECTOR && !prot[cur_sec]) begin
            launch_d = 1'b1;
            op_d     = OP_SECT;
          end else if (at_a && data == CMD_CHIP) begin
            launch_d = 1'b1;
            op_d     = OP_CHIP;
          end
        end
        default: st_d = DS_READ;
      endcase
      if (data == CMD_RESET && st_q != DS_PDATA) begin
        st_d     = DS_READ;
        launch_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= DS_READ;
      launch_q <= 1'b0;
      op_q     <= OP_NONE;
      sec_q    <= '0;
      off_q    <= '0;
      data_q   <= '0;
    end else begin
      st_q     <= st_d;
      launch_q <= launch_d;
      op_q     <= op_d;
      if (acc) begin
        sec_q  <= cur_sec;
        off_q  <= addr[OFF_W-1:0];
        data_q <= data;
      end
    end
  end

  assign launch      = launch_q;
  assign launch_op   = op_q;
  assign launch_sec  = sec_q;
  assign launch_off  = off_q;
  assign launch_data = data_q;

  // R10
  lowv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && lowv) |=> !launch_q);

endmodule

// File: rtl/fcc_op_sequencer.sv
module fcc_op_sequencer
  import fcc_pkg::*;
#(
  parameter int SEC_W        = 3,
  parameter int OFF_W        = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 256,
  localparam int NSEC        = 1 << SEC_W,
  localparam int MAXC        = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W       = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  op_e              launch_op,
  input  logic [SEC_W-1:0] launch_sec,
  input  logic [OFF_W-1:0] launch_off,
  input  logic [7:0]       launch_data,
  input  logic [NSEC-1:0]  prot,
  output logic             busy,
  output logic             poll_bit,
  output logic             wr_en,
  output logic [SEC_W-1:0] wr_sec,
  output logic [OFF_W-1:0] wr_off,
  output logic [7:0]       wr_data,
  output logic             clr_en,
  output logic [SEC_W-1:0] clr_sec
);

  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [OFF_W-1:0] OFF_LAST   = {OFF_W{1'b1}};
  localparam logic [SEC_W-1:0] SEC_LAST   = {SEC_W{1'b1}};

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [7:0]       dat_q, dat_d;
  logic             chip_q, chip_d;
  logic             ers_q, ers_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sec_d   = sec_q;
    off_d   = off_q;
    dat_d   = dat_q;
    chip_d  = chip_q;
    ers_d   = ers_q;
    wr_en   = 1'b0;
    wr_data = dat_q;
    clr_en  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (launch) begin
          cnt_d = '0;
          off_d = '0;
          unique case (launch_op)
            OP_PROG: begin
              st_d  = SQ_PROG;
              sec_d = launch_sec;
              off_d = launch_off;
              dat_d = launch_data;
              ers_d = 1'b0;
            end
            OP_SECT: begin
              st_d   = SQ_PRE;
              sec_d  = launch_sec;
              chip_d = 1'b0;
              ers_d  = 1'b1;
            end
            OP_CHIP: begin
              st_d   = SQ_PRE;
              sec_d  = '0;
              chip_d = 1'b1;
              ers_d  = 1'b1;
            end
            default: st_d = SQ_IDLE;
          endcase
        end
      end
      SQ_PROG: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == PROG_LAST) begin
          wr_en = 1'b1;
          st_d  = SQ_IDLE;
        end
      end
      SQ_PRE: begin
        if (prot[sec_q]) begin
          if (chip_q && sec_q != SEC_LAST) begin
            sec_d = sec_q + 1'b1;
            off_d = '0;
          end else begin
            st_d = SQ_IDLE;
          end
        end else begin
          wr_en   = 1'b1;
          wr_data = 8'h00;
          off_d   = off_q + 1'b1;
          if (off_q == OFF_LAST) begin
            st_d  = SQ_ERASE;
            cnt_d = '0;
          end
        end
      end
      SQ_ERASE: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == ERASE_LAST) begin
          clr_en = 1'b1;
          if (chip_q && sec_q != SEC_LAST) begin
            sec_d = sec_q + 1'b1;
            off_d = '0;
            st_d  = SQ_PRE;
          end else begin
            st_d = SQ_IDLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      sec_q  <= '0;
      off_q  <= '0;
      dat_q  <= '0;
      chip_q <= 1'b0;
      ers_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sec_q  <= sec_d;
      off_q  <= off_d;
      dat_q  <= dat_d;
      chip_q <= chip_d;
      ers_q  <= ers_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign poll_bit = ers_q ? 1'b0 : ~dat_q[7];
  assign wr_sec   = sec_q;
  assign wr_off   = off_q;
  assign clr_sec  = sec_q;

  // R12
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE) |-> !launch);

  // R7
  clear_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (st_q == SQ_ERASE && $past(st_q) == SQ_ERASE));

endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int SEC_W  = 3,
  parameter int OFF_W  = 4,
  localparam int NSEC  = 1 << SEC_W,
  localparam int DEPTH = 1 << OFF_W,
  localparam int IDX_W = SEC_W + OFF_W,
  localparam int WORDS = NSEC * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEC-1:0]  prot,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic             clr_en,
  input  logic [SEC_W-1:0] clr_sec,
  input  logic [SEC_W-1:0] rd_sec,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte
);

  logic [7:0]       mem_q [WORDS];
  logic [7:0]       mem_d [WORDS];
  logic [NSEC-1:0]  sec_clr;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       old_byte;

  assign wr_idx   = {wr_sec, wr_off};
  assign old_byte = mem_q[wr_idx];
  assign rd_byte  = mem_q[{rd_sec, rd_off}];

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign sec_clr[s] = clr_en && (clr_sec == SEC_W'(s));
  end

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      mem_d[i] = mem_q[i];
      if (sec_clr[i / DEPTH]) begin
        mem_d[i] = 8'hFF;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        mem_d[i] = mem_q[i] & wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  // R9
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !prot[wr_sec]);

  // R9
  prot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !prot[clr_sec]);

  // R3
  only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> ((mem_q[$past(wr_idx)] & ~$past(old_byte)) == 8'h00));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int SEC_W        = 3,
  parameter int OFF_W        = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 256,
  localparam int NSEC        = 1 << SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  input  logic [NSEC-1:0]   prot_mask,
  input  logic              low_vdd
);

  logic             launch;
  op_e              launch_op;
  logic [SEC_W-1:0] launch_sec;
  logic [OFF_W-1:0] launch_off;
  logic [7:0]       launch_data;
  logic             busy, poll_bit;
  logic             wr_en, clr_en;
  logic [SEC_W-1:0] wr_sec, clr_sec;
  logic [OFF_W-1:0] wr_off;
  logic [7:0]       wr_data;
  logic [7:0]       rd_byte;

  logic [7:0]       dout_q, dout_d;
  logic             tog_q, tog_d;
  logic             rd_cyc;

  fcc_cmd_decoder #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .OFF_W(OFF_W), .UNL_W(15)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(cs && wr), .lowv(low_vdd), .busy(busy),
    .addr(addr), .data(din), .prot(prot_mask),
    .launch(launch), .launch_op(launch_op), .launch_sec(launch_sec),
    .launch_off(launch_off), .launch_data(launch_data)
  );

  fcc_op_sequencer #(
    .SEC_W(SEC_W), .OFF_W(OFF_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_sec(launch_sec), .launch_off(launch_off), .launch_data(launch_data),
    .prot(prot_mask), .busy(busy), .poll_bit(poll_bit),
    .wr_en(wr_en), .wr_sec(wr_sec), .wr_off(wr_off), .wr_data(wr_data),
    .clr_en(clr_en), .clr_sec(clr_sec)
  );

  fcc_array #(
    .SEC_W(SEC_W), .OFF_W(OFF_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .prot(prot_mask),
    .wr_en(wr_en), .wr_sec(wr_sec), .wr_off(wr_off), .wr_data(wr_data),
    .clr_en(clr_en), .clr_sec(clr_sec),
    .rd_sec(addr[ADDR_W-1 -: SEC_W]), .rd_off(addr[OFF_W-1:0]),
    .rd_byte(rd_byte)
  );

  assign rd_cyc = cs && rd;

  always_comb begin
    dout_d = dout_q;
    tog_d  = tog_q;
    if (rd_cyc) begin
      if (busy) begin
        tog_d  = ~tog_q;
        dout_d = {poll_bit, ~tog_q, 6'b000000};
      end else begin
        dout_d = rd_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 8'h00;
      tog_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      tog_q  <= tog_d;
    end
  end

  assign dout = dout_q;

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && busy && $past(rd_cyc && busy)) |=> (dout[6] != $past(dout[6])));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, wr, rd, low_vdd;
  logic [16:0] addr;
  logic [7:0]  din, dout, prot_mask;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(
    .ADDR_W(17), .SEC_W(3), .OFF_W(4), .PROG_CYCLES(16), .ERASE_CYCLES(40)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .din(din), .dout(dout), .prot_mask(prot_mask), .low_vdd(low_vdd)
  );

  // {address, data, expected byte after program}
  localparam int NVEC = 6;
  localparam logic [32:0] VEC [NVEC] = '{
    {17'h00003, 8'h3C, 8'h3C},
    {17'h00003, 8'h0F, 8'h0C},
    {17'h04007, 8'hA5, 8'hA5},
    {17'h1C00F, 8'h00, 8'h00},
    {17'h08001, 8'hFE, 8'hFE},
    {17'h08001, 8'h7F, 8'h7E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [16:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    v = dout;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAA, 8'h55);
  endtask

  task automatic cmd_prog(input logic [16:0] a, input logic [7:0] d);
    unlock();
    bus_wr(17'h05555, 8'hA0);
    bus_wr(a, d);
    @(negedge clk);
  endtask

  task automatic cmd_erase(input logic [16:0] a, input logic [7:0] c);
    unlock();
    bus_wr(17'h05555, 8'h80);
    unlock();
    bus_wr(a, c);
    @(negedge clk);
  endtask

  task automatic wait_done(input logic [16:0] a, output int reads);
    logic [7:0] v1, v2;
    bit done = 0;
    reads = 0;
    while (!done && reads < 20000) begin
      bus_rd(a, v1);
      bus_rd(a, v2);
      reads += 2;
      if (v1[6] == v2[6]) done = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, s1, s2;
    int nr;
    cs = 0; wr = 0; rd = 0; low_vdd = 0; prot_mask = 8'h00;
    addr = '0; din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 dout before read", dout, 8'h00);
    bus_rd(17'h00000, v); check("R1 sector0 erased", v, 8'hFF);
    bus_rd(17'h1C00F, v); check("R1 sector7 erased", v, 8'hFF);

    // R2 R3 R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      cmd_prog(VEC[i][32:16], VEC[i][15:8]);
      wait_done(VEC[i][32:16], nr);
      bus_rd(VEC[i][32:16], v);
      check("R2 R3 R6 program result", v, VEC[i][7:0]);
    end

    // R4 R5 status during program, R12 writes ignored while busy
    cmd_prog(17'h0C002, 8'h5A);
    bus_rd(17'h0C002, s1);
    bus_rd(17'h0C002, s2);
    check("R4 program dq7", {7'b0, s1[7]}, 8'h01);
    check("R5 toggle bit", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    check("R5 low bits zero", {2'b0, s1[5:0]}, 8'h00);
    cmd_prog(17'h0C003, 8'h00);
    wait_done(17'h0C002, nr);
    bus_rd(17'h0C002, v); check("R6 return to read", v, 8'h5A);
    bus_rd(17'h0C003, v); check("R12 busy write ignored", v, 8'hFF);

    // R7 sector erase of sector 0
    cmd_erase(17'h00000, 8'h30);
    bus_rd(17'h00003, s1);
    check("R4 erase dq7", {7'b0, s1[7]}, 8'h00);
    wait_done(17'h00003, nr);
    check("R7 erase lasts walk plus wait", (nr >= 10) ? 8'h01 : 8'h00, 8'h01);
    bus_rd(17'h00003, v); check("R7 target cleared", v, 8'hFF);
    bus_rd(17'h04007, v); check("R7 neighbour kept", v, 8'hA5);

    // R9 protection
    cmd_prog(17'h10002, 8'h11);
    wait_done(17'h10002, nr);
    prot_mask = 8'h10;
    cmd_prog(17'h10002, 8'h00);
    bus_rd(17'h10002, v); check("R9 protected program not busy", v, 8'h11);
    cmd_erase(17'h10000, 8'h30);
    bus_rd(17'h10002, v); check("R9 protected sector erase", v, 8'h11);

    // R8 chip erase skipping protected sector 4
    cmd_erase(17'h05555, 8'h10);
    wait_done(17'h1C00F, nr);
    bus_rd(17'h1C00F, v); check("R8 sector7 cleared", v, 8'hFF);
    bus_rd(17'h04007, v); check("R8 sector1 cleared", v, 8'hFF);
    bus_rd(17'h0C002, v); check("R8 sector3 cleared", v, 8'hFF);
    bus_rd(17'h10002, v); check("R8 R9 protected kept", v, 8'h11);
    prot_mask = 8'h00;

    // R10 low supply
    low_vdd = 1'b1;
    cmd_prog(17'h08005, 8'h00);
    low_vdd = 1'b0;
    bus_rd(17'h08005, v); check("R10 low supply inhibit", v, 8'hFF);
    bus_wr(17'h08005, 8'h00);
    @(negedge clk);
    bus_rd(17'h08005, v); check("R10 sequence not advanced", v, 8'hFF);

    // R11 bad command byte
    unlock();
    bus_wr(17'h05555, 8'h12);
    bus_wr(17'h08006, 8'h00);
    @(negedge clk);
    bus_rd(17'h08006, v); check("R11 bad command", v, 8'hFF);
    // R11 reset byte mid sequence
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAA, 8'hF0);
    bus_wr(17'h05555, 8'hA0);
    bus_wr(17'h08007, 8'h00);
    @(negedge clk);
    bus_rd(17'h08007, v); check("R11 reset byte", v, 8'hFF);
    // R11 wrong unlock address
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h05555, 8'h55);
    bus_wr(17'h05555, 8'hA0);
    bus_wr(17'h08008, 8'h00);
    @(negedge clk);
    bus_rd(17'h08008, v); check("R11 wrong address", v, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule